// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates the addresses of one memory port's bursts. It holds three registers. The counter drives the address. The mask decides which counter bits may advance. The mirror keeps the last start address written into the counter. A 3-bit operation select is sampled on every rising clock edge. It can load a start address, advance the counter, clear the counting bits, or load or restore the mask.

The mask is meant to be a run of 1s in the low bits with 0s above it. Bits under a 0 in the mask are frozen, so only the low window counts and the burst wraps inside that window. Clearing mask bit 0 freezes the LSB, so each increment then advances the address by two.

An increment may find every counting bit already at 1. The counter then reloads the mirror value instead of rolling over, so the same burst repeats, and the active-low counter interrupt pulses for one cycle. All outputs are registered. The reset is synchronous and active high.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the address becomes 0, the mask becomes all ones and `cnt_int_n` becomes 1, regardless of `op`.
- R2: Operation code 1 (load) writes `din` into both the counter and the mirror; the address shows `din` after the edge.
- R3: Operation code 2 (increment) with mask all ones adds one to the address. Counter bits whose mask bit is 0 never change on an increment that does not reload.
- R4: With mask bit 0 cleared and a contiguous run of 1s above it, an increment holds the LSB and advances the address by two.
- R5: If an increment finds every counter bit under a mask 1 already set, the counter takes the mirror value and `cnt_int_n` is 0 for exactly the following cycle; at all other times `cnt_int_n` is 1.
- R6: Operation code 3 (counter reset) clears the counter bits under mask 1s, keeps the others, and writes the result into the mirror.
- R7: Operation code 4 (mask load) writes `din` into the mask; operation code 5 (mask reset) sets the mask to all ones.
- R8: Only codes 1, 2 and 3 change the address, and only codes 4 and 5 change the mask.
- R9: Only codes 1 and 3 change the mirror; increments and mask operations leave the reload target unchanged.
- R10: Codes 0, 6 and 7 are hold: address, mask and interrupt are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high master reset |
| op | input | 3 | Operation select (0 hold, 1 load, 2 increment, 3 counter reset, 4 mask load, 5 mask reset, 6/7 hold) |
| din | input | WIDTH | Value for counter load or mask load |
| addr | output | WIDTH | Current counter value (burst address) |
| mask | output | WIDTH | Current mask register |
| cnt_int_n | output | 1 | Active-low one-cycle counter interrupt |

## Verification
The bench builds the block with WIDTH set to 8, smaller than the default of 15. At that width one full unmasked pass of 240 increments from a mid-range start, up to 0xFF and back to the mirror, runs quickly. A start value other than zero separates a mirror reload from a plain roll-over. Narrow masks such as 0x0E, 0x0F and 0x03 exercise the step-by-two, short-wrap and frozen-upper-bit cases with small literal expected values.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_INC   = 3'd2,
    OP_CRST  = 3'd3,
    OP_MLOAD = 3'd4,
    OP_MRST  = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } op_e;
endpackage

// File: rtl/burst_step.sv
// Combinational next-address logic for a masked increment.
module burst_step #(
  parameter int WIDTH = 15
) (
  input  logic [WIDTH-1:0] cnt,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] inc_val,
  output logic             at_end
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] filled;
  logic [WIDTH-1:0] summed;

  // Frozen bits are forced to 1 so the carry ripples through them.
  always_comb begin
    filled  = cnt | ~mask;
    summed  = filled + ONE;
    inc_val = (summed & mask) | (cnt & ~mask);
    at_end  = ((cnt & mask) == mask);
  end
endmodule

// File: rtl/burst_mask_reg.sv
module burst_mask_reg
  import burst_pkg::*;
#(
  parameter int WIDTH = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  op_e              op,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else begin
      case (op)
        OP_MLOAD: mask_q <= din;
        OP_MRST:  mask_q <= '1;
        default:  mask_q <= mask_q;
      endcase
    end
  end

  // R7
  mask_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MRST) |=> (mask_q == {WIDTH{1'b1}}));

  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MLOAD) |=> (mask_q == $past(din)));

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op != OP_MLOAD && op != OP_MRST) |=> $stable(mask_q));
endmodule

// File: rtl/burst_counter.sv
module burst_counter
  import burst_pkg::*;
#(
  parameter int WIDTH = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  op_e              op,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] mask_i,
  output logic [WIDTH-1:0] cnt_q,
  output logic             int_n_q
);
  logic [WIDTH-1:0] mir_q;
  logic [WIDTH-1:0] inc_val;
  logic             at_end;

  burst_step #(.WIDTH(WIDTH)) u_step (
    .cnt     (cnt_q),
    .mask    (mask_i),
    .inc_val (inc_val),
    .at_end  (at_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      mir_q   <= '0;
      int_n_q <= 1'b1;
    end else begin
      int_n_q <= 1'b1;
      case (op)
        OP_LOAD: begin
          cnt_q <= din;
          mir_q <= din;
        end
        OP_INC: begin
          if (at_end) begin
            cnt_q   <= mir_q;
            int_n_q <= 1'b0;
          end else begin
            cnt_q <= inc_val;
          end
        end
        OP_CRST: begin
          cnt_q <= cnt_q & ~mask_i;
          mir_q <= cnt_q & ~mask_i;
        end
        default: begin
          cnt_q <= cnt_q;
          mir_q <= mir_q;
        end
      endcase
    end
  end

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op != OP_LOAD && op != OP_INC && op != OP_CRST) |=> $stable(cnt_q));

  // R9
  mirror_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op != OP_LOAD && op != OP_CRST) |=> $stable(mir_q));

  // R5
  int_source_chk: assert property (@(posedge clk) disable iff (rst)
    !int_n_q |-> ($past(op) == OP_INC));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    !int_n_q |-> (cnt_q == mir_q));

  // R3
  frozen_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_INC) |=> (!int_n_q || ((cnt_q & ~mask_i) == ($past(cnt_q) & ~mask_i))));

  // R6
  crst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CRST) |=> (((cnt_q & mask_i) == '0) && (cnt_q == mir_q)));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int WIDTH = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] addr,
  output logic [WIDTH-1:0] mask,
  output logic             cnt_int_n
);
  op_e op_sel;
  assign op_sel = op_e'(op);

  burst_mask_reg #(.WIDTH(WIDTH)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .op     (op_sel),
    .din    (din),
    .mask_q (mask)
  );

  burst_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .op      (op_sel),
    .din     (din),
    .mask_i  (mask),
    .cnt_q   (addr),
    .int_n_q (cnt_int_n)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (addr == '0 && mask == {WIDTH{1'b1}} && cnt_int_n));
endmodule

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   op  = 3'd0;
  logic [W-1:0] din = '0;
  logic [W-1:0] addr;
  logic [W-1:0] mask;
  logic         cnt_int_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  burst_addr_gen #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .op(op), .din(din),
    .addr(addr), .mask(mask), .cnt_int_n(cnt_int_n)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Apply one operation for a single edge, then return to hold.
  task automatic do_op(input logic [2:0] o, input logic [W-1:0] v);
    @(negedge clk);
    op  = o;
    din = v;
    @(negedge clk);
    op  = 3'd0;
    din = '0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    op  = 3'd2;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    op  = 3'd0;
    chk("R1 addr", addr, 0);
    chk("R1 mask", mask, 8'hFF);
    chk("R1 int", cnt_int_n, 1);
  endtask

  task automatic t_load_inc();
    do_op(3'd1, 8'h35);
    chk("R2 load", addr, 8'h35);
    repeat (3) do_op(3'd2, 8'h00);
    chk("R3 inc by one", addr, 8'h38);
    chk("R3 int high", cnt_int_n, 1);
    do_op(3'd6, 8'h11);
    do_op(3'd7, 8'h22);
    do_op(3'd0, 8'h33);
    chk("R10 hold addr", addr, 8'h38);
    chk("R10 hold mask", mask, 8'hFF);
    chk("R10 hold int", cnt_int_n, 1);
  endtask

  task automatic t_step_two();
    do_op(3'd4, 8'h0E);
    chk("R7 mask load", mask, 8'h0E);
    do_op(3'd1, 8'h21);
    do_op(3'd2, 8'h00);
    chk("R4 step two", addr, 8'h23);
    do_op(3'd2, 8'h00);
    chk("R4 step two again", addr, 8'h25);
    repeat (5) do_op(3'd2, 8'h00);
    chk("R4 window top", addr, 8'h2F);
    chk("R5 int high before end", cnt_int_n, 1);
    @(negedge clk);
    op = 3'd2;
    @(negedge clk);
    op = 3'd0;
    chk("R5 reload from mirror", addr, 8'h21);
    chk("R5 int low", cnt_int_n, 0);
    @(negedge clk);
    chk("R5 int one cycle", cnt_int_n, 1);
  endtask

  task automatic t_wrap_full();
    do_op(3'd5, 8'h00);
    chk("R7 mask reset", mask, 8'hFF);
    do_op(3'd1, 8'hFC);
    repeat (3) do_op(3'd2, 8'h00);
    chk("R3 reach top", addr, 8'hFF);
    @(negedge clk);
    op = 3'd2;
    @(negedge clk);
    op = 3'd0;
    chk("R5 full wrap reload", addr, 8'hFC);
    chk("R5 full wrap int", cnt_int_n, 0);
  endtask

  task automatic t_crst();
    do_op(3'd4, 8'h0F);
    do_op(3'd1, 8'hA7);
    do_op(3'd2, 8'h00);
    chk("R3 upper held", addr, 8'hA8);
    do_op(3'd3, 8'h55);
    chk("R6 counter reset", addr, 8'hA0);
    chk("R8 mask kept by counter ops", mask, 8'h0F);
    repeat (15) do_op(3'd2, 8'h00);
    chk("R6 count to top", addr, 8'hAF);
    do_op(3'd2, 8'h00);
    chk("R6 mirror holds cleared value", addr, 8'hA0);
    do_op(3'd4, 8'h03);
    chk("R8 addr kept by mask load", addr, 8'hA0);
    do_op(3'd5, 8'h00);
    chk("R8 addr kept by mask reset", addr, 8'hA0);
  endtask

  task automatic t_mirror_hold();
    do_op(3'd4, 8'h03);
    do_op(3'd1, 8'h50);
    do_op(3'd2, 8'h00);
    do_op(3'd5, 8'h00);
    do_op(3'd4, 8'h03);
    do_op(3'd2, 8'h00);
    do_op(3'd2, 8'h00);
    chk("R9 count", addr, 8'h53);
    do_op(3'd2, 8'h00);
    chk("R9 mirror untouched", addr, 8'h50);
  endtask

  task automatic t_full_range();
    int lows = 0;
    do_op(3'd5, 8'h00);
    do_op(3'd1, 8'h10);
    for (int i = 0; i < 239; i++) begin
      do_op(3'd2, 8'h00);
      if (!cnt_int_n) lows++;
    end
    chk("R3 full range top", addr, 8'hFF);
    chk("R5 no early int", lows, 0);
    do_op(3'd2, 8'h00);
    chk("R5 reload not zero", addr, 8'h10);
  endtask

  task automatic t_reset_again();
    do_op(3'd4, 8'h07);
    do_op(3'd1, 8'h9A);
    t_reset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_load_inc();
    t_step_two();
    t_wrap_full();
    t_crst();
    t_mirror_hold();
    t_full_range();
    t_reset_again();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule